// File: doc/BRIEF.md
# Low-Power Clock Gating Enable Register

This block keeps one enable bit for each of five peripherals (two timers, a window watchdog, a serial port and an I2C controller). Each bit says whether that peripheral's clocks keep running while the system sits in a low-power mode. Outside those modes every clock runs. The block turns the stored bits and the current power mode into a bus-clock enable and a kernel-clock enable for each peripheral. These outputs feed clock-gating cells that sit outside the block.

Software reaches the bits through a single-word read/write port. Each access carries a secure attribute and a privileged attribute. An external security controller decides, peripheral by peripheral, whether a bit is secure. The block also takes two privilege-protection settings, one for the secure domain and one for the non-secure domain.

The filter works on each bit on its own. A blocked bit reads as zero and ignores the write. Bits in the same word that the access may touch are updated normally. A blocked access never raises an error. A hardware option input can hold the watchdog bit at one.

Top module: `lpcg_ctrl`

## Requirements
- R1: While reset is active and after it is released, every stored enable bit is 0 and a read returns 0. The only exception is bit 2 while the hardware watchdog option is active.
- R2: The bit layout is bit0 timer A, bit1 timer B, bit2 watchdog, bit3 serial port, bit4 I2C. A permitted write stores the written value in each bit, so it can both set and clear. A permitted read returns the stored bits one clock edge after the write.
- R3: When a peripheral's secure input is 1, a non-secure access to that peripheral's bit reads 0 and leaves the bit unchanged. Secure accesses may reach both secure and non-secure bits.
- R4: Writes are filtered bit by bit. In one write, the permitted bits take the written data and the blocked bits keep their values.
- R5: When the secure privilege-protection input is 1, an unprivileged access to a secure bit reads 0 and leaves the bit unchanged.
- R6: When the non-secure privilege-protection input is 1, an unprivileged access to a non-secure bit reads 0 and leaves the bit unchanged.
- R7: Data bits 31 down to 5 always read 0, and writing them has no effect.
- R8: While the hardware watchdog option is 1, bit 2 reads 1 and its bus enable stays on in low-power modes, even if 0 is written in the same cycle. After the option drops, the bit stays 1 until software writes 0 to it.
- R9: Mode encoding is 00 run, 01 sleep, 10 stop; 11 is handled as a low-power mode. In run mode every bus enable is 1. In any other mode, bus enable i equals the effective bit i.
- R10: The kernel enables of the timers, the serial port and the I2C follow the same rule as their bus enables. The watchdog kernel enable is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_data | input | 32 | Write data |
| acc_secure | input | 1 | Access is issued by a secure master |
| acc_priv | input | 1 | Access is privileged |
| rd_data | output | 32 | Filtered read data for the current access attributes |
| periph_sec | input | 5 | Per-peripheral secure attribute |
| spriv_en | input | 1 | Privilege protection for secure bits |
| nspriv_en | input | 1 | Privilege protection for non-secure bits |
| hw_wdg_opt | input | 1 | Hardware watchdog option, forces bit 2 on |
| lp_mode | input | 2 | Current power mode |
| bus_clk_en | output | 5 | Per-peripheral bus clock enable |
| ker_clk_en | output | 5 | Per-peripheral kernel clock enable |

## Verification
Two functions can land on the same cycle: a software write that clears the watchdog bit, and the hardware option that forces it on. The bench raises the option and issues a write of zero in that same cycle. It then checks that the bit reads 1 and that the watchdog bus enable stays on in sleep mode. It also checks that the bit keeps its value after the option drops.

The second overlap is a single write word that holds both permitted and blocked bits, split by security and by privilege. Every bit is then checked against its own attribute.

// File: rtl/lpcg_pkg.sv
package lpcg_pkg;

    localparam int unsigned NPERIPH = 5;
    localparam int unsigned DATA_W  = 32;

    localparam int unsigned IDX_TMR_A = 0;
    localparam int unsigned IDX_TMR_B = 1;
    localparam int unsigned IDX_WDG   = 2;
    localparam int unsigned IDX_UART  = 3;
    localparam int unsigned IDX_I2C   = 4;

    // Peripherals that own a kernel clock (the watchdog has only a bus clock)
    localparam logic [NPERIPH-1:0] KER_PRESENT =
        NPERIPH'((1 << IDX_TMR_A) | (1 << IDX_TMR_B) | (1 << IDX_UART) | (1 << IDX_I2C));

    typedef enum logic [1:0] {
        LP_RUN   = 2'b00,
        LP_SLEEP = 2'b01,
        LP_STOP  = 2'b10,
        LP_RSVD  = 2'b11
    } lp_mode_e;

    typedef struct packed {
        logic secure;
        logic priv;
    } acc_attr_t;

    typedef struct packed {
        logic sec_priv;
        logic nsec_priv;
    } priv_cfg_t;

    // Whether an access with the given attributes may touch one bit
    function automatic logic bit_reachable(input logic bit_secure,
                                           input acc_attr_t attr,
                                           input priv_cfg_t cfg);
        logic dom_ok;
        logic priv_ok;
        dom_ok  = !bit_secure || attr.secure;
        priv_ok = attr.priv || !(bit_secure ? cfg.sec_priv : cfg.nsec_priv);
        return dom_ok && priv_ok;
    endfunction

    function automatic logic is_low_power(input lp_mode_e m);
        return m != LP_RUN;
    endfunction

endpackage

// File: rtl/lpcg_access_filter.sv
module lpcg_access_filter
    import lpcg_pkg::*;
#(
    parameter int unsigned N = NPERIPH
) (
    input  logic [N-1:0] periph_sec,
    input  acc_attr_t    attr,
    input  priv_cfg_t    cfg,
    output logic [N-1:0] acc_mask
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign acc_mask[i] = bit_reachable(periph_sec[i], attr, cfg);
    end

endmodule

// File: rtl/lpcg_enable_regs.sv
module lpcg_enable_regs #(
    parameter int unsigned N       = lpcg_pkg::NPERIPH,
    parameter int unsigned WDG_IDX = lpcg_pkg::IDX_WDG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [N-1:0] wr_bits,
    input  logic [N-1:0] wr_mask,
    input  logic         hw_force,
    output logic [N-1:0] en_q,
    output logic [N-1:0] en_eff
);

    localparam logic [N-1:0] FORCE_ONE = N'(1) << WDG_IDX;

    logic [N-1:0] force_vec;
    logic [N-1:0] en_d;

    assign force_vec = hw_force ? FORCE_ONE : '0;

    always_comb begin
        en_d = en_q;
        if (wr_en) begin
            en_d = (en_q & ~wr_mask) | (wr_bits & wr_mask);
        end
        en_d = en_d | force_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en_eff = en_q | force_vec;

endmodule

// File: rtl/lpcg_clk_gate.sv
module lpcg_clk_gate
    import lpcg_pkg::*;
#(
    parameter int unsigned   N        = NPERIPH,
    parameter logic [N-1:0]  KER_MASK = KER_PRESENT
) (
    input  lp_mode_e     mode,
    input  logic [N-1:0] en_eff,
    output logic [N-1:0] bus_en,
    output logic [N-1:0] ker_en
);

    logic run_on;
    logic lp_on;

    assign lp_on  = is_low_power(mode);
    assign run_on = !lp_on;

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign bus_en[i] = run_on || (lp_on && en_eff[i]);
        if (KER_MASK[i]) begin : g_ker
            assign ker_en[i] = run_on || (lp_on && en_eff[i]);
        end else begin : g_noker
            assign ker_en[i] = 1'b0;
        end
    end

endmodule

// File: rtl/lpcg_ctrl.sv
module lpcg_ctrl
    import lpcg_pkg::*;
#(
    parameter int unsigned  N        = NPERIPH,
    parameter int unsigned  DW       = DATA_W,
    parameter int unsigned  WDG_IDX  = IDX_WDG,
    parameter logic [N-1:0] KER_MASK = KER_PRESENT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          acc_secure,
    input  logic          acc_priv,
    output logic [DW-1:0] rd_data,
    input  logic [N-1:0]  periph_sec,
    input  logic          spriv_en,
    input  logic          nspriv_en,
    input  logic          hw_wdg_opt,
    input  logic [1:0]    lp_mode,
    output logic [N-1:0]  bus_clk_en,
    output logic [N-1:0]  ker_clk_en
);

    acc_attr_t    attr;
    priv_cfg_t    cfg;
    logic [N-1:0] acc_mask;
    logic [N-1:0] en_q;
    logic [N-1:0] en_eff;
    logic         unused_wr_hi;

    assign attr = '{secure: acc_secure, priv: acc_priv};
    assign cfg  = '{sec_priv: spriv_en, nsec_priv: nspriv_en};

    // Upper data bits have no storage behind them
    assign unused_wr_hi = ^wr_data[DW-1:N];

    lpcg_access_filter #(.N(N)) u_filt (
        .periph_sec (periph_sec),
        .attr       (attr),
        .cfg        (cfg),
        .acc_mask   (acc_mask)
    );

    lpcg_enable_regs #(.N(N), .WDG_IDX(WDG_IDX)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_bits  (wr_data[N-1:0]),
        .wr_mask  (acc_mask),
        .hw_force (hw_wdg_opt),
        .en_q     (en_q),
        .en_eff   (en_eff)
    );

    lpcg_clk_gate #(.N(N), .KER_MASK(KER_MASK)) u_gate (
        .mode   (lp_mode_e'(lp_mode)),
        .en_eff (en_eff),
        .bus_en (bus_clk_en),
        .ker_en (ker_clk_en)
    );

    assign rd_data = {{(DW-N){1'b0}}, en_eff & acc_mask};

endmodule

// File: rtl/lpcg_ctrl_chk.sv
module lpcg_ctrl_chk #(
    parameter int unsigned  N        = lpcg_pkg::NPERIPH,
    parameter int unsigned  DW       = lpcg_pkg::DATA_W,
    parameter int unsigned  WDG_IDX  = lpcg_pkg::IDX_WDG,
    parameter logic [N-1:0] KER_MASK = lpcg_pkg::KER_PRESENT
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          acc_secure,
    input logic          acc_priv,
    input logic [N-1:0]  periph_sec,
    input logic          spriv_en,
    input logic          nspriv_en,
    input logic          hw_wdg_opt,
    input logic [1:0]    lp_mode,
    input logic [DW-1:0] rd_data,
    input logic [N-1:0]  bus_clk_en,
    input logic [N-1:0]  ker_clk_en,
    input logic [N-1:0]  en_q
);

    localparam logic [N-1:0] WDG_BIT = N'(1) << WDG_IDX;

    logic [N-1:0] force_now;
    assign force_now = hw_wdg_opt ? WDG_BIT : '0;

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (en_q == '0));

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !hw_wdg_opt) |=> $stable(en_q));

    a_r3_ns_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !acc_secure) |=>
        (((en_q ^ $past(en_q)) & $past(periph_sec) & ~$past(force_now)) == '0));

    a_r3_ns_read_zero: assert property (@(posedge clk) disable iff (rst)
        !acc_secure |-> ((rd_data[N-1:0] & periph_sec) == '0));

    a_r5_spriv_read_zero: assert property (@(posedge clk) disable iff (rst)
        (spriv_en && !acc_priv) |-> ((rd_data[N-1:0] & periph_sec) == '0));

    a_r6_nspriv_read_zero: assert property (@(posedge clk) disable iff (rst)
        (nspriv_en && !acc_priv) |-> ((rd_data[N-1:0] & ~periph_sec) == '0));

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[DW-1:N] == '0);

    a_r8_force_on: assert property (@(posedge clk) disable iff (rst)
        hw_wdg_opt |-> ((bus_clk_en & WDG_BIT) == WDG_BIT));

    a_r9_run_all_on: assert property (@(posedge clk) disable iff (rst)
        (lp_mode == 2'b00) |-> (&bus_clk_en));

    a_r10_ker_follows_bus: assert property (@(posedge clk) disable iff (rst)
        ker_clk_en == (bus_clk_en & KER_MASK));

endmodule

bind lpcg_ctrl lpcg_ctrl_chk #(
    .N(N), .DW(DW), .WDG_IDX(WDG_IDX), .KER_MASK(KER_MASK)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .acc_secure (acc_secure),
    .acc_priv   (acc_priv),
    .periph_sec (periph_sec),
    .spriv_en   (spriv_en),
    .nspriv_en  (nspriv_en),
    .hw_wdg_opt (hw_wdg_opt),
    .lp_mode    (lp_mode),
    .rd_data    (rd_data),
    .bus_clk_en (bus_clk_en),
    .ker_clk_en (ker_clk_en),
    .en_q       (en_q)
);

// File: tb/lpcg_ctrl_tb.sv
`timescale 1ns/1ps
module lpcg_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        acc_secure = 1'b1;
    logic        acc_priv = 1'b1;
    logic [31:0] rd_data;
    logic [4:0]  periph_sec = '0;
    logic        spriv_en = 1'b0;
    logic        nspriv_en = 1'b0;
    logic        hw_wdg_opt = 1'b0;
    logic [1:0]  lp_mode = 2'b00;
    logic [4:0]  bus_clk_en;
    logic [4:0]  ker_clk_en;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lpcg_ctrl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .acc_secure(acc_secure), .acc_priv(acc_priv), .rd_data(rd_data),
        .periph_sec(periph_sec), .spriv_en(spriv_en), .nspriv_en(nspriv_en),
        .hw_wdg_opt(hw_wdg_opt), .lp_mode(lp_mode),
        .bus_clk_en(bus_clk_en), .ker_clk_en(ker_clk_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [31:0] d, input logic s, input logic p);
        @(negedge clk);
        wr_data = d; acc_secure = s; acc_priv = p; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic s, input logic p, output logic [31:0] v);
        acc_secure = s; acc_priv = p;
        #0.5;
        v = rd_data;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        @(negedge clk);
        do_rd(1'b1, 1'b1, v);
        chk("R1 read during reset", v, 32'h0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        do_rd(1'b1, 1'b1, v);
        chk("R1 read after reset", v, 32'h0);
        chk("R9 run bus all on", {27'h0, bus_clk_en}, 32'h1F);
        lp_mode = 2'b01; #0.5;
        chk("R1 sleep bus all off", {27'h0, bus_clk_en}, 32'h0);
        lp_mode = 2'b00;
    endtask

    task automatic t_rw;
        logic [31:0] v;
        do_wr(32'hFFFF_FFFF, 1'b0, 1'b1);
        do_rd(1'b0, 1'b1, v);
        chk("R7 upper bits read zero", v, 32'h1F);
        do_wr(32'h0000_000A, 1'b0, 1'b1);
        do_rd(1'b0, 1'b1, v);
        chk("R2 write 0x0A", v, 32'h0A);
        do_wr(32'h0, 1'b0, 1'b1);
        do_rd(1'b0, 1'b1, v);
        chk("R2 clear", v, 32'h0);
    endtask

    task automatic t_gate;
        do_wr(32'h1D, 1'b1, 1'b1);
        lp_mode = 2'b01; #0.5;
        chk("R9 sleep bus", {27'h0, bus_clk_en}, 32'h1D);
        chk("R10 sleep kernel", {27'h0, ker_clk_en}, 32'h19);
        lp_mode = 2'b10; #0.5;
        chk("R9 stop bus", {27'h0, bus_clk_en}, 32'h1D);
        lp_mode = 2'b11; #0.5;
        chk("R9 mode 11 low power", {27'h0, bus_clk_en}, 32'h1D);
        lp_mode = 2'b00; #0.5;
        chk("R10 run kernel", {27'h0, ker_clk_en}, 32'h1B);
    endtask

    task automatic t_secure;
        logic [31:0] v;
        do_wr(32'h0, 1'b1, 1'b1);
        periph_sec = 5'b00110;
        do_wr(32'h1F, 1'b0, 1'b1);
        do_rd(1'b0, 1'b1, v);
        chk("R3 ns read hides secure bits", v, 32'h19);
        do_rd(1'b1, 1'b1, v);
        chk("R3 ns write ignored on secure bits", v, 32'h19);
        do_wr(32'h06, 1'b1, 1'b1);
        do_rd(1'b1, 1'b1, v);
        chk("R3 secure master writes all", v, 32'h06);
        do_rd(1'b0, 1'b1, v);
        chk("R3 ns read zero", v, 32'h0);
        do_wr(32'h01, 1'b0, 1'b1);
        do_rd(1'b1, 1'b1, v);
        chk("R4 mixed word per-bit", v, 32'h07);
    endtask

    task automatic t_priv;
        logic [31:0] v;
        spriv_en = 1'b1;
        do_rd(1'b1, 1'b0, v);
        chk("R5 unpriv read hides secure bits", v, 32'h01);
        do_wr(32'h18, 1'b1, 1'b0);
        do_rd(1'b1, 1'b1, v);
        chk("R5 unpriv write keeps secure bits", v, 32'h1E);
        spriv_en = 1'b0; nspriv_en = 1'b1;
        do_wr(32'h0, 1'b0, 1'b0);
        do_rd(1'b1, 1'b1, v);
        chk("R6 ns unpriv write ignored", v, 32'h1E);
        do_wr(32'h0, 1'b1, 1'b0);
        do_rd(1'b1, 1'b1, v);
        chk("R6 split by privilege", v, 32'h18);
        do_rd(1'b0, 1'b0, v);
        chk("R6 ns unpriv read zero", v, 32'h0);
        nspriv_en = 1'b0; periph_sec = '0;
    endtask

    task automatic t_force;
        logic [31:0] v;
        do_wr(32'h0, 1'b1, 1'b1);
        @(negedge clk);
        hw_wdg_opt = 1'b1;
        wr_data = 32'h0; acc_secure = 1'b1; acc_priv = 1'b1; wr_en = 1'b1;
        #0.5;
        chk("R8 forced read immediate", rd_data, 32'h04);
        @(negedge clk);
        wr_en = 1'b0;
        do_rd(1'b1, 1'b1, v);
        chk("R8 write zero while forced", v, 32'h04);
        lp_mode = 2'b01; #0.5;
        chk("R8 wdg bus on in sleep", {27'h0, bus_clk_en}, 32'h04);
        chk("R10 wdg kernel off", {27'h0, ker_clk_en}, 32'h0);
        lp_mode = 2'b00;
        hw_wdg_opt = 1'b0;
        @(negedge clk);
        do_rd(1'b1, 1'b1, v);
        chk("R8 bit held after release", v, 32'h04);
        do_wr(32'h0, 1'b1, 1'b1);
        do_rd(1'b1, 1'b1, v);
        chk("R8 cleared by software", v, 32'h0);
    endtask

    initial begin
        t_reset();
        t_rw();
        t_gate();
        t_secure();
        t_priv();
        t_force();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule